// File: doc/BRIEF.md
# Strobe-Paced Memory Transfer Channel

This block moves data in one direction between a serial peripheral and system memory, one unit at a time, without processor help. Software loads a 32-bit memory pointer and a 16-bit unit count through a small register port. After that, every ready strobe from the peripheral causes exactly one memory access through a request/grant port. In the transmit direction that access is a read, and the data goes to the peripheral. In the receive direction it is a write of the data the peripheral supplied with its strobe.

After each access the pointer moves forward by the unit size and the count goes down by one. A unit is one byte for narrow characters and two bytes for wide characters. When the count reaches zero the channel stops and raises an end-of-transfer interrupt. The interrupt stays high until software writes a new nonzero count. A peripheral with both a receive path and a transmit path uses two instances, one with the direction input tied each way.

Top module: `strobe_dma_chan`

## Requirements
- R1: After reset the pointer and count read back as zero, `eot_irq` is low, `mem_req` is low and `per_tx_valid` is low.
- R2: A register write with `reg_sel`=0 loads the pointer from all 32 bits of `reg_wdata`. With `reg_sel`=1 it loads the count from bits 15:0. `reg_rdata` shows the selected register combinationally, with the count zero-extended.
- R3: A strobe on `per_ready` while the count is nonzero and no access is outstanding raises `mem_req` on the next cycle. At that point `mem_addr` equals the pointer, `mem_we` equals the inverse of `dir_tx`, and `mem_wide` equals `wide_char`.
- R4: `mem_req` and `mem_addr` stay unchanged until a cycle in which `mem_gnt` is high. That cycle completes the access, and `mem_req` is low on the following cycle.
- R5: Each completed access adds 1 to the pointer (2 when `wide_char`=1), wrapping modulo 2^32, and subtracts 1 from the count.
- R6: In receive mode (`dir_tx`=0), `mem_wdata` carries the `per_rx_data` value that was sampled with the launching strobe.
- R7: In transmit mode (`dir_tx`=1), the cycle after the grant shows `per_tx_valid` high for exactly one cycle, with `per_tx_data` equal to the `mem_rdata` value present at the grant. In receive mode `per_tx_valid` stays low.
- R8: A strobe that arrives while an access is outstanding is ignored, so one launching strobe gives exactly one access.
- R9: While the count is zero, strobes start no access.
- R10: The access that brings the count to zero sets `eot_irq`. It stays set through further strobes and pointer writes. A count write with a nonzero value clears it on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_tx | input | 1 | 1 = memory to peripheral, 0 = peripheral to memory |
| wide_char | input | 1 | 1 = two-byte units, 0 = one-byte units |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = pointer, 1 = count |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register value |
| per_ready | input | 1 | Peripheral ready strobe |
| per_rx_data | input | 16 | Received data from the peripheral |
| per_tx_data | output | 16 | Data delivered to the peripheral |
| per_tx_valid | output | 1 | One-cycle pulse marking per_tx_data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_wide | output | 1 | 1 = two-byte access |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | 16 | Read data, valid while mem_gnt is high |
| eot_irq | output | 1 | End-of-transfer interrupt |

## Verification
A strobe driven at a falling edge is registered at the next rising edge, so the request and its address are checked at the falling edge that follows, one cycle after the strobe. A grant takes effect at one rising edge. The dropped request, the transmit pulse, the moved pointer and the lower count are all checked at the falling edge after that rising edge. Register readback is combinational and is sampled a moment after the select changes. The sweep covers both directions, both unit sizes and grant waits of zero to two cycles. It injects a stray strobe during each wait and checks one cycle after completion that it started nothing.

// File: rtl/strobe_dma_chan.sv
module strobe_dma_chan #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_tx,
  input  logic          wide_char,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          per_ready,
  input  logic [DW-1:0] per_rx_data,
  output logic [DW-1:0] per_tx_data,
  output logic          per_tx_valid,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  output logic          eot_irq
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] hold_q, txd_q;
  logic          busy_q, txv_q, eot_q;

  logic          wr_ptr, wr_cnt, launch, done;
  logic [CW-1:0] new_cnt;
  logic [AW-1:0] step;

  assign wr_ptr  = reg_wr & ~reg_sel;
  assign wr_cnt  = reg_wr & reg_sel;
  assign new_cnt = reg_wdata[CW-1:0];
  assign launch  = per_ready & ~busy_q & (cnt_q != '0) & ~wr_cnt;
  assign done    = busy_q & mem_gnt & ~wr_cnt;
  assign step    = wide_char ? AW'(2) : AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      txd_q  <= '0;
      txv_q  <= 1'b0;
      eot_q  <= 1'b0;
    end else begin
      if (wr_cnt)      busy_q <= 1'b0;
      else if (launch) busy_q <= 1'b1;
      else if (done)   busy_q <= 1'b0;

      if (launch) hold_q <= per_rx_data;

      if (wr_ptr)    ptr_q <= reg_wdata;
      else if (done) ptr_q <= ptr_q + step;

      if (wr_cnt)    cnt_q <= new_cnt;
      else if (done) cnt_q <= cnt_q - CNT_ONE;

      if (wr_cnt && new_cnt != '0)     eot_q <= 1'b0;
      else if (done && cnt_q == CNT_ONE) eot_q <= 1'b1;

      txv_q <= done & dir_tx;
      if (done && dir_tx) txd_q <= mem_rdata;
    end
  end

  assign reg_rdata    = reg_sel ? AW'(cnt_q) : ptr_q;
  assign mem_req      = busy_q;
  assign mem_we       = ~dir_tx;
  assign mem_wide     = wide_char;
  assign mem_addr     = ptr_q;
  assign mem_wdata    = hold_q;
  assign per_tx_data  = txd_q;
  assign per_tx_valid = txv_q;
  assign eot_irq      = eot_q;
endmodule

// File: rtl/strobe_dma_chan_chk.sv
module strobe_dma_chan_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dir_tx,
  input logic          reg_wr,
  input logic          reg_sel,
  input logic [AW-1:0] reg_wdata,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic [AW-1:0] mem_addr,
  input logic          per_tx_valid,
  input logic          eot_irq,
  input logic [CW-1:0] cnt_q
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !reg_wr |=> mem_req); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !reg_wr |=> $stable(mem_addr)); // R4
  AST_ONE_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> !mem_req); // R8
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cnt_q != '0); // R9
  AST_TXV_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_tx_valid) |-> $past(mem_req && mem_gnt && dir_tx)); // R7
  AST_EOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    eot_irq && !(reg_wr && reg_sel && reg_wdata[CW-1:0] != '0) |=> eot_irq); // R10
endmodule

bind strobe_dma_chan strobe_dma_chan_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
  .per_tx_valid(per_tx_valid), .eot_irq(eot_irq), .cnt_q(cnt_q)
);

// File: tb/tb_strobe_dma_chan.sv
module tb_strobe_dma_chan;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dir_tx = 1'b0, wide_char = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata, mem_addr;
  logic per_ready = 1'b0, per_tx_valid, mem_req, mem_we, mem_wide, mem_gnt = 1'b0, eot_irq;
  logic [15:0] per_rx_data = '0, per_tx_data, mem_wdata, mem_rdata = '0;
  int total = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  strobe_dma_chan dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [31:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  function automatic logic [15:0] mem_val(input logic [31:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  task automatic xfer(input logic [31:0] ea, input bit tx, input bit wd, input int lat, input logic [15:0] rxd);
    per_ready = 1'b1; per_rx_data = rxd;
    @(negedge clk); per_ready = 1'b0; per_rx_data = ~rxd;
    chk(mem_req && mem_addr == ea && mem_we == !tx && mem_wide == wd, "R3 req/addr", mem_addr, ea);
    if (!tx) chk(mem_wdata == rxd, "R6 wdata", {16'h0, mem_wdata}, {16'h0, rxd});
    for (int i = 0; i < lat; i++) begin
      if (i == 0) per_ready = 1'b1;
      @(negedge clk); per_ready = 1'b0;
      chk(mem_req && mem_addr == ea, "R4 hold", mem_addr, ea);
    end
    mem_gnt = 1'b1; mem_rdata = mem_val(ea);
    @(negedge clk); mem_gnt = 1'b0; mem_rdata = '0;
    chk(!mem_req, "R4 drop", {31'h0, mem_req}, 32'h0);
    chk(per_tx_valid == tx, "R7 valid", {31'h0, per_tx_valid}, {31'h0, tx});
    if (tx) chk(per_tx_data == mem_val(ea), "R7 data", {16'h0, per_tx_data}, {16'h0, mem_val(ea)});
    @(negedge clk);
    chk(!mem_req, "R8 stray ignored", {31'h0, mem_req}, 32'h0);
    chk(!per_tx_valid, "R7 one pulse", {31'h0, per_tx_valid}, 32'h0);
  endtask

  task automatic run(input bit tx, input bit wd, input int lat, input logic [31:0] base, input int n);
    logic [31:0] v, ea;
    dir_tx = tx; wide_char = wd;
    wr(1'b0, base);
    wr(1'b1, 32'(n));
    chk(!eot_irq, "R10 clear on arm", {31'h0, eot_irq}, 32'h0);
    rd(1'b0, v); chk(v == base, "R2 ptr rd", v, base);
    rd(1'b1, v); chk(v == 32'(n), "R2 cnt rd", v, 32'(n));
    ea = base;
    for (int k = 0; k < n; k++) begin
      xfer(ea, tx, wd, lat, 16'hC300 + 16'(k * 7 + lat));
      ea = ea + (wd ? 32'd2 : 32'd1);
      rd(1'b0, v); chk(v == ea, "R5 ptr step", v, ea);
      rd(1'b1, v); chk(v == 32'(n - k - 1), "R5 cnt dec", v, 32'(n - k - 1));
      chk(eot_irq == (k == n - 1), "R10 eot", {31'h0, eot_irq}, {31'h0, k == n - 1});
    end
    per_ready = 1'b1; @(negedge clk); per_ready = 1'b0; @(negedge clk);
    chk(!mem_req, "R9 idle strobe", {31'h0, mem_req}, 32'h0);
    chk(eot_irq, "R10 sticky", {31'h0, eot_irq}, 32'h1);
    wr(1'b0, 32'h0000_0040);
    chk(eot_irq, "R10 sticky ptr wr", {31'h0, eot_irq}, 32'h1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); chk(v == 0, "R1 ptr", v, 0);
    rd(1'b1, v); chk(v == 0, "R1 cnt", v, 0);
    chk(!eot_irq && !mem_req && !per_tx_valid, "R1 outputs", {29'h0, eot_irq, mem_req, per_tx_valid}, 0);
    per_ready = 1'b1; @(negedge clk); per_ready = 1'b0; @(negedge clk);
    chk(!mem_req, "R9 no arm", {31'h0, mem_req}, 0);
    wr(1'b1, 32'hABCD_0000);
    rd(1'b1, v); chk(v == 0, "R2 cnt low bits", v, 0);
    for (int t = 0; t < 2; t++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 3; l++)
          run(t[0], w[0], l, 32'h1000_0000 + 32'(t * 256 + w * 64 + l * 16), l + 1);
    run(1'b0, 1'b1, 1, 32'hFFFF_FFFF, 2);
    run(1'b1, 1'b0, 0, 32'hFFFF_FFFE, 3);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule